// File: doc/BRIEF.md
# Degenerate Triangle Index Culler

This block sits in the input assembly stage of a graphics pipeline, between the reader of the index buffer and the stage that fetches vertices. Vertex indices stream in one per beat and are taken three at a time as a triangle list. Each completed triangle has its three indices compared pairwise. When any two of them are equal, the triangle has no area. It is dropped at once, so no vertex fetch or shading work is ever asked for it. Triangles that survive leave through a one-entry output stage that holds its contents under backpressure.

The input carries a last-of-draw flag on the beat. If the flag comes on the first or second index of a group, the unfinished group is thrown away, and the next index starts a new group. Two saturating counters, with a parameter width of 32 by default, count the culled triangles and the passed ones.

Top module: `tri_index_culler`

## Requirements
- R1: While and just after the synchronous reset `rst`, triValid is 0, idxReady is 1 and both counters read 0.
- R2: Every three accepted indices (idxValid and idxReady high at a clock edge) form one triangle. The first, second and third index of the group appear on triIdx0, triIdx1 and triIdx2.
- R3: A triangle is culled, and never appears at the output, when idx0 equals idx1, idx1 equals idx2, or idx0 equals idx2.
- R4: A triangle with three distinct indices is presented exactly once, and triangles leave in the order they were completed.
- R5: While triValid is high and triReady is low, triValid stays high and the three output indices hold their values.
- R6: idxReady goes low only when a stalled triangle is held at the output and the next accepted index would complete a group. It is high in every other cycle.
- R7: An accepted index with idxLast high in position one or two of a group discards that partial group. The following index begins a fresh group. idxLast on the third index does not change how that triangle is handled.
- R8: culledCount goes up by one in the cycle after the third index of a culled triangle is accepted.
- R9: passedCount goes up by one in the cycle after the third index of a passing triangle is accepted.
- R10: Both counters stop at all ones and do not wrap.
- R11: The output has one cycle of latency. A passing triangle shows triValid in the cycle after its third index is accepted. With triReady held high, an index is accepted on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idxValid | input | 1 | Index beat valid |
| idxReady | output | 1 | Block can take an index |
| idxData | input | IDX_W | Vertex index |
| idxLast | input | 1 | Beat is the last index of the draw |
| triValid | output | 1 | Output triangle valid |
| triReady | input | 1 | Downstream takes the triangle |
| triIdx0 | output | IDX_W | First index of the triangle |
| triIdx1 | output | IDX_W | Second index of the triangle |
| triIdx2 | output | IDX_W | Third index of the triangle |
| culledCount | output | CNT_W | Culled triangles, saturating |
| passedCount | output | CNT_W | Passed triangles, saturating |

## Verification
Two things can happen in the same cycle: the output stage hands a triangle downstream, and a newly completed triangle is loaded into that same stage. A third index can also arrive while a held triangle is waiting for triReady. The bench provokes both cases with dense index streams under a triReady that is either held high or toggled at random. A behavioural queue model predicts idxReady, the triangle sequence and both counters on every clock. The bench flags any lost, duplicated or reordered triangle, and any wrong stall decision.

// File: rtl/tri_cull_pkg.sv
package tri_cull_pkg;
  typedef struct packed {
    logic cap0;     // store incoming index as vertex 0
    logic cap1;     // store incoming index as vertex 1
    logic loadOut;  // load completed triangle into output stage
    logic incCull;  // bump culled counter
    logic incPass;  // bump passed counter
  } ctrl_strobe_t;

  localparam int NUM_CNT = 2;
  localparam int CNT_CULL = 0;
  localparam int CNT_PASS = 1;
endpackage

// File: rtl/tri_cull_ctrl.sv
module tri_cull_ctrl
  import tri_cull_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         idxValid,
  input  logic         idxLast,
  input  logic         triReady,
  input  logic         degenerate,
  output logic         idxReady,
  output logic         triValid,
  output ctrl_strobe_t strobe
);
  typedef enum logic [1:0] {SLOT0 = 2'd0, SLOT1 = 2'd1, SLOT2 = 2'd2} slot_t;

  slot_t slotQ, slotD;
  logic  outValidQ, outValidD;
  logic  accept, isThird, drain, complete;

  assign isThird  = (slotQ == SLOT2);
  assign drain    = outValidQ && triReady;
  assign idxReady = !isThird || !outValidQ || triReady;
  assign accept   = idxValid && idxReady;
  assign complete = accept && isThird;

  always_comb begin
    strobe.cap0    = accept && (slotQ == SLOT0);
    strobe.cap1    = accept && (slotQ == SLOT1);
    strobe.loadOut = complete && !degenerate;
    strobe.incCull = complete && degenerate;
    strobe.incPass = complete && !degenerate;
  end

  always_comb begin
    slotD = slotQ;
    if (accept) begin
      if (isThird || idxLast) slotD = SLOT0;
      else if (slotQ == SLOT0) slotD = SLOT1;
      else slotD = SLOT2;
    end
    outValidD = outValidQ;
    if (strobe.loadOut) outValidD = 1'b1;
    else if (drain)     outValidD = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slotQ     <= SLOT0;
      outValidQ <= 1'b0;
    end else begin
      slotQ     <= slotD;
      outValidQ <= outValidD;
    end
  end

  assign triValid = outValidQ;
endmodule

// File: rtl/tri_cull_dp.sv
module tri_cull_dp
  import tri_cull_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_strobe_t       strobe,
  input  logic [IDX_W-1:0]   idxData,
  output logic               degenerate,
  output logic [IDX_W-1:0]   triIdx0,
  output logic [IDX_W-1:0]   triIdx1,
  output logic [IDX_W-1:0]   triIdx2,
  output logic [CNT_W-1:0]   culledCount,
  output logic [CNT_W-1:0]   passedCount
);
  localparam int NUM_V = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [IDX_W-1:0] vReg0, vReg1;
  logic [IDX_W-1:0] cand [NUM_V];
  logic [NUM_V-1:0] pairEq;
  logic [IDX_W-1:0] outReg [NUM_V];
  logic [CNT_W-1:0] cnt [NUM_CNT];
  logic             cntInc [NUM_CNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      vReg0 <= '0;
      vReg1 <= '0;
    end else begin
      if (strobe.cap0) vReg0 <= idxData;
      if (strobe.cap1) vReg1 <= idxData;
    end
  end

  assign cand[0] = vReg0;
  assign cand[1] = vReg1;
  assign cand[2] = idxData;

  // every unordered vertex pair: (0,1) (1,2) (0,2)
  genvar p;
  generate
    for (p = 0; p < NUM_V; p++) begin : g_pair
      localparam int A = (p == 2) ? 0 : p;
      localparam int B = (p == 2) ? 2 : p + 1;
      assign pairEq[p] = (cand[A] == cand[B]);
    end
  endgenerate
  assign degenerate = |pairEq;

  genvar v;
  generate
    for (v = 0; v < NUM_V; v++) begin : g_out
      always_ff @(posedge clk) begin
        if (rst)                 outReg[v] <= '0;
        else if (strobe.loadOut) outReg[v] <= cand[v];
      end
    end
  endgenerate

  assign triIdx0 = outReg[0];
  assign triIdx1 = outReg[1];
  assign triIdx2 = outReg[2];

  assign cntInc[CNT_CULL] = strobe.incCull;
  assign cntInc[CNT_PASS] = strobe.incPass;

  genvar c;
  generate
    for (c = 0; c < NUM_CNT; c++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst)                             cnt[c] <= '0;
        else if (cntInc[c] && cnt[c] != CNT_MAX) cnt[c] <= cnt[c] + 1'b1;
      end
    end
  endgenerate

  assign culledCount = cnt[CNT_CULL];
  assign passedCount = cnt[CNT_PASS];
endmodule

// File: rtl/tri_index_culler.sv
module tri_index_culler
  import tri_cull_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idxValid,
  output logic             idxReady,
  input  logic [IDX_W-1:0] idxData,
  input  logic             idxLast,
  output logic             triValid,
  input  logic             triReady,
  output logic [IDX_W-1:0] triIdx0,
  output logic [IDX_W-1:0] triIdx1,
  output logic [IDX_W-1:0] triIdx2,
  output logic [CNT_W-1:0] culledCount,
  output logic [CNT_W-1:0] passedCount
);
  ctrl_strobe_t strobe;
  logic         degenerate;

  tri_cull_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .idxValid   (idxValid),
    .idxLast    (idxLast),
    .triReady   (triReady),
    .degenerate (degenerate),
    .idxReady   (idxReady),
    .triValid   (triValid),
    .strobe     (strobe)
  );

  tri_cull_dp #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .idxData     (idxData),
    .degenerate  (degenerate),
    .triIdx0     (triIdx0),
    .triIdx1     (triIdx1),
    .triIdx2     (triIdx2),
    .culledCount (culledCount),
    .passedCount (passedCount)
  );
endmodule

// File: rtl/tri_cull_chk.sv
module tri_cull_chk #(
  parameter int IDX_W = 16,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             idxReady,
  input logic             triValid,
  input logic             triReady,
  input logic [IDX_W-1:0] triIdx0,
  input logic [IDX_W-1:0] triIdx1,
  input logic [IDX_W-1:0] triIdx2,
  input logic [CNT_W-1:0] culledCount,
  input logic [CNT_W-1:0] passedCount
);
  // R3
  no_degen_out_chk: assert property (@(posedge clk) disable iff (rst)
    triValid |-> (triIdx0 != triIdx1) && (triIdx1 != triIdx2) && (triIdx0 != triIdx2));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (triValid && !triReady) |=> triValid && $stable(triIdx0) && $stable(triIdx1) && $stable(triIdx2));

  // R6
  ready_low_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !idxReady |-> (triValid && !triReady));

  // R8
  cull_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (culledCount == $past(culledCount)) || (culledCount == $past(culledCount) + 1'b1));

  // R9
  pass_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (passedCount == $past(passedCount)) || (passedCount == $past(passedCount) + 1'b1));

  // R10
  cull_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (culledCount == {CNT_W{1'b1}}) |=> (culledCount == {CNT_W{1'b1}}));

  // R10
  pass_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (passedCount == {CNT_W{1'b1}}) |=> (passedCount == {CNT_W{1'b1}}));
endmodule

bind tri_index_culler tri_cull_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .idxReady    (idxReady),
  .triValid    (triValid),
  .triReady    (triReady),
  .triIdx0     (triIdx0),
  .triIdx1     (triIdx1),
  .triIdx2     (triIdx2),
  .culledCount (culledCount),
  .passedCount (passedCount)
);

// File: tb/test_tri_index_culler.sv
`timescale 1ns/1ps
module test_tri_index_culler;
  localparam int IDX_W = 8;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idxValid = 1'b0, idxLast = 1'b0, triReady = 1'b0;
  logic [IDX_W-1:0] idxData = '0;
  logic idxReady, triValid;
  logic [IDX_W-1:0] triIdx0, triIdx1, triIdx2;
  logic [CNT_W-1:0] culledCount, passedCount;

  always #2.5 clk = ~clk;

  tri_index_culler #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_tri_index_culler (
    .clk(clk), .rst(rst), .idxValid(idxValid), .idxReady(idxReady),
    .idxData(idxData), .idxLast(idxLast), .triValid(triValid),
    .triReady(triReady), .triIdx0(triIdx0), .triIdx1(triIdx1),
    .triIdx2(triIdx2), .culledCount(culledCount), .passedCount(passedCount));

  int checks = 0, failures = 0;
  bit done = 0;
  bit randReady = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int grp[$];
  bit mOutV = 0;
  int mT0 = 0, mT1 = 0, mT2 = 0;
  int mCull = 0, mPass = 0;

  function automatic bit mReady();
    return !(grp.size() == 2 && mOutV && !triReady);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      grp.delete(); mOutV = 0; mCull = 0; mPass = 0;
    end else begin
      bit acc, drn, cmp;
      int t[3];
      acc = idxValid && mReady();
      drn = mOutV && triReady;
      cmp = 0;
      if (acc) begin
        grp.push_back(int'(idxData));
        if (grp.size() == 3) begin
          cmp = 1; t[0] = grp[0]; t[1] = grp[1]; t[2] = grp[2]; grp.delete();
        end else if (idxLast) grp.delete();
      end
      if (cmp && (t[0] == t[1] || t[1] == t[2] || t[0] == t[2])) begin
        if (mCull < CMAX) mCull++;
        if (drn) mOutV = 0;
      end else if (cmp) begin
        mOutV = 1; mT0 = t[0]; mT1 = t[1]; mT2 = t[2];
        if (mPass < CMAX) mPass++;
      end else if (drn) mOutV = 0;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(triValid == mOutV, "R4/R11 triValid", triValid, mOutV);
      if (mOutV && triValid) begin
        check(triIdx0 == mT0, "R2 triIdx0", triIdx0, mT0);
        check(triIdx1 == mT1, "R2 triIdx1", triIdx1, mT1);
        check(triIdx2 == mT2, "R2 triIdx2", triIdx2, mT2);
      end
      check(idxReady == mReady(), "R6 idxReady", idxReady, mReady());
      check(culledCount == mCull, "R8 culledCount", culledCount, mCull);
      check(passedCount == mPass, "R9 passedCount", passedCount, mPass);
    end
  end

  always @(posedge clk) if (randReady) #1 triReady = $urandom_range(0, 1);

  task automatic sendIdx(int v, bit last);
    bit r;
    idxValid = 1; idxData = v[IDX_W-1:0]; idxLast = last;
    do begin
      @(negedge clk); r = idxReady;
      @(posedge clk); #1;
    end while (!r);
    idxValid = 0; idxLast = 0;
  endtask

  task automatic sendTri(int a, int b, int c);
    sendIdx(a, 0); sendIdx(b, 0); sendIdx(c, 0);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c0, s0;
    bit [IDX_W-1:0] h0, h1, h2;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(triValid == 0, "R1 triValid", triValid, 0);
    check(idxReady == 1, "R1 idxReady", idxReady, 1);
    check(culledCount == 0 && passedCount == 0, "R1 counters", culledCount + passedCount, 0);
    rst = 0; triReady = 1;
    idle(2);

    // R2/R3/R11: pass, each pair equal, all equal, pass
    sendTri(1, 2, 3);
    @(negedge clk);
    check(triValid && triIdx0 == 1 && triIdx2 == 3, "R11 latency", triValid, 1);
    @(posedge clk); #1;
    sendTri(4, 4, 5);
    sendTri(6, 7, 7);
    sendTri(8, 9, 8);
    sendTri(5, 5, 5);
    sendTri(10, 11, 12);
    idle(3);
    check(culledCount == 4, "R3 R8 culled total", culledCount, 4);
    check(passedCount == 2, "R4 R9 passed total", passedCount, 2);

    // R5/R6: stall with triangle held, two more indices accepted then stall
    triReady = 0;
    sendTri(20, 21, 22);
    sendIdx(30, 0); sendIdx(31, 0);
    idxValid = 1; idxData = 32;
    @(negedge clk);
    h0 = triIdx0; h1 = triIdx1; h2 = triIdx2;
    check(idxReady == 0, "R6 stall ready", idxReady, 0);
    idle(4);
    @(negedge clk);
    check(triValid && triIdx0 == h0 && triIdx1 == h1 && triIdx2 == h2, "R5 hold", triIdx0, h0);
    idxValid = 0;
    @(posedge clk); #1;
    triReady = 1;
    sendIdx(32, 0);
    idle(2);
    check(passedCount == 4, "R9 after stall", passedCount, 4);

    // R7: partial groups discarded
    sendIdx(40, 1);
    sendIdx(41, 0); sendIdx(42, 1);
    sendTri(43, 44, 45);
    @(negedge clk);
    check(triValid && triIdx0 == 43 && triIdx1 == 44 && triIdx2 == 45, "R7 regroup", triIdx0, 43);
    @(posedge clk); #1;
    sendIdx(50, 0); sendIdx(51, 0); sendIdx(52, 1);
    idle(2);
    check(passedCount == 6, "R7 last on third", passedCount, 6);

    // R10: saturation
    for (int i = 0; i < 20; i++) sendTri(i, i, i + 1);
    for (int i = 0; i < 20; i++) sendTri(i, i + 1, i + 2);
    idle(2);
    check(culledCount == CMAX, "R10 culled sat", culledCount, CMAX);
    check(passedCount == CMAX, "R10 passed sat", passedCount, CMAX);

    // random mix under random backpressure (model compares each cycle)
    rst = 1; idle(2); rst = 0;
    randReady = 1;
    for (int i = 0; i < 2000; i++)
      sendIdx($urandom_range(0, 5), ($urandom_range(0, 15) == 0));
    randReady = 0; #1 triReady = 1;
    idle(5);
    c0 = culledCount; s0 = passedCount;
    check(c0 == mCull && s0 == mPass, "R8 R9 random end", c0 + s0, mCull + mPass);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule